// File: doc/BRIEF.md
# DPLL loop filter with mini-holdover

This block is the digital loop filter of a telecom-grade DPLL. A signed phase-error sample arrives with a strobe. It drives a proportional path and an integral accumulator. Their sum, clamped to programmable limits, is registered as the frequency-control word for the numerically controlled oscillator. The gains are arithmetic right-shift amounts looked up from a bandwidth index and a damping code. The bandwidth index is taken from either an acquisition setting or a locked setting, chosen automatically from the lock flag when auto-bandwidth is on.

When the reference-valid flag drops, error samples are cut off in the same cycle and the filter enters mini-holdover. In mini-holdover the output is taken from a delayed copy of the integrator, captured by a ring of snapshot registers on a slow periodic tick, so the held value is always between one and two tick periods old. When the free-run option is set, the output is instead the nominal word plus a programmable offset. Mini-holdover ends when the reference returns, and filtering then resumes from the untouched integrator. It also ends when the full-holdover command is asserted; that command holds the output at the clamped integrator value.

Top module: `dpll_loop_filter`

## Requirements
- R1: While ref_ok_i is 0 and hold_cmd_i is 0, error samples are ignored from that same cycle on (the integrator is unchanged), and mini_hold_o is 1 one clock later.
- R2: In mini-holdover with free_run_i at 0, freq_o equals the clamped integrator value held in the oldest of SNAP_N snapshot slots. The slots are written in turn, one every TICK_CYC cycles, and only while ref_ok_i is 1 and hold_cmd_i is 0. After TICK_CYC*SNAP_N or more cycles of normal operation with a constant integrator, that slot holds that integrator value.
- R3: mini_hold_o is 0 one clock after any cycle with ref_ok_i=1 or hold_cmd_i=1. While hold_cmd_i is 1, samples are ignored and freq_o becomes the integrator value clamped to the limits (no proportional term).
- R4: In mini-holdover with free_run_i at 1, freq_o becomes NOM_FREQ + mclk_ofs_i, clamped to the limits.
- R5: The bandwidth index is acq_bw_i when auto_bw_i=1 and locked_i=0. Otherwise it is lck_bw_i.
- R6: Bandwidth index codes 0..5 stand for 18, 35, 70, 140, 280 and 400 Hz; codes 6 and 7 act as 5. With effective index b and effective damping code d, the proportional shift is P_BASE-b and the integral shift is I_BASE-2b+2(d-1) (defaults P_BASE=6, I_BASE=12).
- R7: Damping codes 1..5 select damping factors 1.2, 2.5, 5, 10 and 20. Code 0 acts as 1 and codes 6 and 7 act as 5. At index 0 (18 Hz) codes above 3 act as 3, and at index 1 (35 Hz) codes above 4 act as 4.
- R8: On a cycle with err_vld_i=1, ref_ok_i=1 and hold_cmd_i=0, let E = err_i shifted left by ERR_SHL (default 8). The integrator becomes clamp(acc + (E>>>i_shift)), and one clock later freq_o = clamp(acc_new + (E>>>p_shift)). On normal cycles without a strobe, freq_o is unchanged.
- R9: With lim_int_i=1 and freq_o equal to f_min_i or f_max_i, an accepted sample leaves the integrator unchanged; the proportional term still applies.
- R10: freq_o and the integrator are always clamped to the range [f_min_i, f_max_i].
- R11: After mini-holdover ends because the reference returned, filtering continues from the integrator value held before the failure.
- R12: After reset, freq_o is 0, mini_hold_o is 0 and the integrator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_i | input | ERR_W | Signed phase-error sample |
| err_vld_i | input | 1 | Sample strobe |
| ref_ok_i | input | 1 | Reference valid |
| locked_i | input | 1 | Loop phase-locked flag |
| hold_cmd_i | input | 1 | Full-holdover command |
| auto_bw_i | input | 1 | Automatic bandwidth switching enable |
| lim_int_i | input | 1 | Freeze integrator at the frequency limits |
| free_run_i | input | 1 | Mini-holdover uses nominal word plus offset |
| acq_bw_i | input | 3 | Acquisition bandwidth index |
| lck_bw_i | input | 3 | Locked bandwidth index |
| damp_i | input | 3 | Damping code |
| f_min_i | input | FREQ_W | Signed lower frequency limit |
| f_max_i | input | FREQ_W | Signed upper frequency limit |
| mclk_ofs_i | input | FREQ_W | Signed master-clock offset for free-run |
| freq_o | output | FREQ_W | Signed frequency-control word |
| mini_hold_o | output | 1 | Mini-holdover active |

## Verification
The bench builds the block with TICK_CYC=20 instead of a 50 ms count, so several snapshot ticks pass within a few hundred cycles. This lets it separate an integrator value two ticks old from a fresh one. NOM_FREQ is set to 100 so the free-run output differs from a plain offset and from zero. Widths, ERR_SHL and the shift bases stay at their defaults, so every entry of the gain table, including the damping caps at the two lowest bandwidths, is reached through a single sample taken from reset.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  localparam int SH_W     = 5;
  localparam int BW_MAX   = 5;
  localparam int DAMP_MAX = 5;

  typedef struct packed {
    logic [SH_W-1:0] p_sh;
    logic [SH_W-1:0] i_sh;
  } gain_t;
endpackage

// File: rtl/dlf_gain_lut.sv
module dlf_gain_lut
  import dlf_pkg::*;
#(
  parameter int P_BASE = 6,
  parameter int I_BASE = 12
) (
  input  logic       auto_bw_i,
  input  logic       locked_i,
  input  logic [2:0] acq_bw_i,
  input  logic [2:0] lck_bw_i,
  input  logic [2:0] damp_i,
  output gain_t      gain_o
);
  logic [2:0] bw_sel, bw, d_raw, d;

  always_comb begin
    bw_sel = (auto_bw_i && !locked_i) ? acq_bw_i : lck_bw_i;
    bw     = (bw_sel > 3'(BW_MAX)) ? 3'(BW_MAX) : bw_sel;
    if (damp_i == 3'd0)             d_raw = 3'd1;
    else if (damp_i > 3'(DAMP_MAX)) d_raw = 3'(DAMP_MAX);
    else                            d_raw = damp_i;
    // narrow loops cannot use the highest damping settings
    if (bw == 3'd0 && d_raw > 3'd3)      d = 3'd3;
    else if (bw == 3'd1 && d_raw > 3'd4) d = 3'd4;
    else                                 d = d_raw;
    gain_o.p_sh = SH_W'(P_BASE - int'(bw));
    gain_o.i_sh = SH_W'(I_BASE - 2 * int'(bw) + 2 * (int'(d) - 1));
  end
endmodule

// File: rtl/dlf_clamp.sv
module dlf_clamp #(
  parameter int IN_W = 26,
  parameter int W    = 24
) (
  input  logic signed [IN_W-1:0] x_i,
  input  logic signed [W-1:0]    lo_i,
  input  logic signed [W-1:0]    hi_i,
  output logic signed [W-1:0]    y_o
);
  logic signed [IN_W-1:0] lo_x, hi_x;
  assign lo_x = IN_W'(lo_i);
  assign hi_x = IN_W'(hi_i);

  always_comb begin
    if (x_i < lo_x)      y_o = lo_i;
    else if (x_i > hi_x) y_o = hi_i;
    else                 y_o = W'(x_i);
  end
endmodule

// File: rtl/dlf_snapshot.sv
module dlf_snapshot #(
  parameter int W        = 24,
  parameter int TICK_CYC = 6250000,
  parameter int SNAP_N   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] d_i,
  output logic signed [W-1:0] old_o
);
  localparam int CW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam int PW = (SNAP_N > 2) ? $clog2(SNAP_N) : 1;

  logic [CW-1:0]       cnt_q;
  logic [PW-1:0]       ptr_q;
  logic                tick, cap;
  logic signed [W-1:0] slot_q [SNAP_N];

  assign tick = (cnt_q == CW'(TICK_CYC - 1));
  assign cap  = tick && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (cap) ptr_q <= (ptr_q == PW'(SNAP_N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SNAP_N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        slot_q[g] <= '0;
      else if (cap && ptr_q == PW'(g))    slot_q[g] <= d_i;
    end
  end

  // next slot to be written is the oldest one
  assign old_o = slot_q[ptr_q];
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
  import dlf_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int FREQ_W   = 24,
  parameter int ERR_SHL  = 8,
  parameter int P_BASE   = 6,
  parameter int I_BASE   = 12,
  parameter int TICK_CYC = 6250000,
  parameter int SNAP_N   = 2,
  parameter logic signed [FREQ_W-1:0] NOM_FREQ = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [ERR_W-1:0]  err_i,
  input  logic                     err_vld_i,
  input  logic                     ref_ok_i,
  input  logic                     locked_i,
  input  logic                     hold_cmd_i,
  input  logic                     auto_bw_i,
  input  logic                     lim_int_i,
  input  logic                     free_run_i,
  input  logic [2:0]               acq_bw_i,
  input  logic [2:0]               lck_bw_i,
  input  logic [2:0]               damp_i,
  input  logic signed [FREQ_W-1:0] f_min_i,
  input  logic signed [FREQ_W-1:0] f_max_i,
  input  logic signed [FREQ_W-1:0] mclk_ofs_i,
  output logic signed [FREQ_W-1:0] freq_o,
  output logic                     mini_hold_o
);
  localparam int E_W = ERR_W + ERR_SHL;
  localparam int S_W = ((E_W > FREQ_W) ? E_W : FREQ_W) + 2;

  gain_t                   gain;
  logic signed [E_W-1:0]   e_scl, p_term, i_term;
  logic signed [S_W-1:0]   acc_sum, out_sum, fr_sum;
  logic signed [FREQ_W-1:0] acc_q, freq_q, acc_cl, acc_nxt, out_cl;
  logic signed [FREQ_W-1:0] hold_cl, fr_cl, snap_old, snap_cl;
  logic                    mini_q, mini_c, smp, at_lim, frz;

  dlf_gain_lut #(.P_BASE(P_BASE), .I_BASE(I_BASE)) u_lut (
    .auto_bw_i(auto_bw_i), .locked_i(locked_i), .acq_bw_i(acq_bw_i),
    .lck_bw_i(lck_bw_i), .damp_i(damp_i), .gain_o(gain)
  );

  assign e_scl  = {err_i, {ERR_SHL{1'b0}}};
  assign p_term = e_scl >>> gain.p_sh;
  assign i_term = e_scl >>> gain.i_sh;

  // isolation from the failed reference is combinational: same cycle
  assign mini_c = !ref_ok_i && !hold_cmd_i;
  assign smp    = err_vld_i && ref_ok_i && !hold_cmd_i;
  assign at_lim = (freq_q == f_min_i) || (freq_q == f_max_i);
  assign frz    = lim_int_i && at_lim;

  assign acc_sum = S_W'(acc_q) + S_W'(i_term);
  dlf_clamp #(.IN_W(S_W), .W(FREQ_W)) u_cl_acc (
    .x_i(acc_sum), .lo_i(f_min_i), .hi_i(f_max_i), .y_o(acc_cl));

  assign acc_nxt = frz ? acc_q : acc_cl;
  assign out_sum = S_W'(acc_nxt) + S_W'(p_term);
  dlf_clamp #(.IN_W(S_W), .W(FREQ_W)) u_cl_out (
    .x_i(out_sum), .lo_i(f_min_i), .hi_i(f_max_i), .y_o(out_cl));

  dlf_clamp #(.IN_W(FREQ_W), .W(FREQ_W)) u_cl_hold (
    .x_i(acc_q), .lo_i(f_min_i), .hi_i(f_max_i), .y_o(hold_cl));

  assign fr_sum = S_W'(NOM_FREQ) + S_W'(mclk_ofs_i);
  dlf_clamp #(.IN_W(S_W), .W(FREQ_W)) u_cl_fr (
    .x_i(fr_sum), .lo_i(f_min_i), .hi_i(f_max_i), .y_o(fr_cl));

  dlf_snapshot #(.W(FREQ_W), .TICK_CYC(TICK_CYC), .SNAP_N(SNAP_N)) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ref_ok_i && !hold_cmd_i),
    .d_i(acc_q), .old_o(snap_old));

  dlf_clamp #(.IN_W(FREQ_W), .W(FREQ_W)) u_cl_snap (
    .x_i(snap_old), .lo_i(f_min_i), .hi_i(f_max_i), .y_o(snap_cl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      freq_q <= '0;
      mini_q <= 1'b0;
    end else begin
      mini_q <= mini_c;
      if (smp && !frz) acc_q <= acc_cl;
      if (hold_cmd_i)  freq_q <= hold_cl;
      else if (mini_c) freq_q <= free_run_i ? fr_cl : snap_cl;
      else if (smp)    freq_q <= out_cl;
    end
  end

  assign freq_o      = freq_q;
  assign mini_hold_o = mini_q;
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
  parameter int FREQ_W = 24,
  parameter logic signed [FREQ_W-1:0] NOM_FREQ = '0
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     err_vld_i,
  input logic                     ref_ok_i,
  input logic                     hold_cmd_i,
  input logic                     free_run_i,
  input logic signed [FREQ_W-1:0] f_min_i,
  input logic signed [FREQ_W-1:0] f_max_i,
  input logic signed [FREQ_W-1:0] mclk_ofs_i,
  input logic signed [FREQ_W-1:0] freq_o,
  input logic                     mini_hold_o
);
  logic                     past_ok;
  logic signed [FREQ_W+1:0] fr_sum;
  logic                     fr_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign fr_sum = (FREQ_W+2)'(NOM_FREQ) + (FREQ_W+2)'(mclk_ofs_i);
  assign fr_in  = (fr_sum >= (FREQ_W+2)'(f_min_i)) && (fr_sum <= (FREQ_W+2)'(f_max_i));

  p_enter_mini_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_ok_i && !hold_cmd_i) |=> mini_hold_o);

  p_leave_mini_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ok_i || hold_cmd_i) |=> !mini_hold_o);

  p_free_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_ok_i && !hold_cmd_i && free_run_i && fr_in)
      |=> (freq_o == $past(fr_sum[FREQ_W-1:0])));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ok_i && !hold_cmd_i && !err_vld_i) |=> $stable(freq_o));

  p_in_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && (freq_o != $past(freq_o)) && $past(f_min_i <= f_max_i))
      |-> (freq_o >= $past(f_min_i) && freq_o <= $past(f_max_i)));
endmodule

bind dpll_loop_filter dlf_checker #(.FREQ_W(FREQ_W), .NOM_FREQ(NOM_FREQ)) u_chk (.*);

// File: tb/sim_dpll_loop_filter.sv
module sim_dpll_loop_filter;
  localparam int FW = 24;
  localparam longint LO_W = -64'sd8388608;
  localparam longint HI_W = 64'sd8388607;

  typedef struct packed {
    logic              au;
    logic              lk;
    logic [2:0]        acq;
    logic [2:0]        lcb;
    logic [2:0]        dmp;
    logic signed [15:0] err;
    logic [4:0]        ps;
    logic [4:0]        is;
  } vec_t;

  // expected shifts from R5/R6/R7
  localparam vec_t VEC [11] = '{
    '{1'b0, 1'b0, 3'd5, 3'd0, 3'd1, 16'sd1000,   5'd6, 5'd12},
    '{1'b1, 1'b0, 3'd5, 3'd0, 3'd1, 16'sd1000,   5'd1, 5'd2},
    '{1'b1, 1'b1, 3'd5, 3'd2, 3'd2, -16'sd1000,  5'd4, 5'd10},
    '{1'b0, 1'b0, 3'd0, 3'd0, 3'd5, 16'sd12345,  5'd6, 5'd16},
    '{1'b0, 1'b1, 3'd0, 3'd0, 3'd3, 16'sd12345,  5'd6, 5'd16},
    '{1'b0, 1'b0, 3'd0, 3'd1, 3'd5, -16'sd3000,  5'd5, 5'd16},
    '{1'b0, 1'b0, 3'd0, 3'd1, 3'd4, -16'sd3000,  5'd5, 5'd16},
    '{1'b0, 1'b0, 3'd0, 3'd3, 3'd5, 16'sd777,    5'd3, 5'd14},
    '{1'b0, 1'b0, 3'd0, 3'd7, 3'd0, -16'sd7,     5'd1, 5'd2},
    '{1'b0, 1'b0, 3'd0, 3'd4, 3'd7, 16'sd20000,  5'd2, 5'd12},
    '{1'b0, 1'b0, 3'd0, 3'd2, 3'd5, 16'sd555,    5'd4, 5'd16}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic signed [15:0] err = '0;
  logic vld = 1'b0, ref_ok = 1'b1, locked = 1'b0, hold = 1'b0;
  logic auto_bw = 1'b0, lim = 1'b0, frun = 1'b0;
  logic [2:0] acq = '0, lcb = '0, dmp = 3'd1;
  logic signed [FW-1:0] fmin = FW'(LO_W), fmax = FW'(HI_W), ofs = '0;
  logic signed [FW-1:0] freq;
  logic mini;

  int n_chk = 0, n_err = 0;
  longint m_acc, m_frq, snap_a;

  always #4 clk = ~clk;

  dpll_loop_filter #(.TICK_CYC(20), .NOM_FREQ(24'sd100)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .err_vld_i(vld),
    .ref_ok_i(ref_ok), .locked_i(locked), .hold_cmd_i(hold),
    .auto_bw_i(auto_bw), .lim_int_i(lim), .free_run_i(frun),
    .acq_bw_i(acq), .lck_bw_i(lcb), .damp_i(dmp),
    .f_min_i(fmin), .f_max_i(fmax), .mclk_ofs_i(ofs),
    .freq_o(freq), .mini_hold_o(mini)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clampv(input longint x, input longint lo, input longint hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  // reference model of R8/R9/R10
  task automatic mdl(input int e, input int ps, input int is);
    longint ev, lo, hi, an;
    lo = longint'(fmin);
    hi = longint'(fmax);
    ev = longint'(e) * 256;
    if (lim && (m_frq == lo || m_frq == hi)) an = m_acc;
    else an = clampv(m_acc + (ev >>> is), lo, hi);
    m_acc = an;
    m_frq = clampv(an + (ev >>> ps), lo, hi);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_acc = 0;
    m_frq = 0;
    @(negedge clk);
  endtask

  task automatic smp(input int e);
    @(negedge clk);
    err = 16'(e);
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    chk("R12 reset freq_o", longint'(freq), 0);
    chk("R12 reset mini_hold_o", longint'(mini), 0);

    // gain table walk: R5 R6 R7 R8
    for (int k = 0; k < 11; k++) begin
      do_reset();
      auto_bw = VEC[k].au; locked = VEC[k].lk;
      acq = VEC[k].acq; lcb = VEC[k].lcb; dmp = VEC[k].dmp;
      smp(int'(VEC[k].err));
      mdl(int'(VEC[k].err), int'(VEC[k].ps), int'(VEC[k].is));
      chk($sformatf("R5/R6/R7 vec %0d freq_o", k), longint'(freq), m_frq);
    end
    auto_bw = 1'b0; locked = 1'b0;

    // R8 idle cycles keep output
    repeat (5) @(negedge clk);
    chk("R8 idle hold", longint'(freq), m_frq);

    // R9 R10 limit handling, p=6 i=12
    lcb = 3'd0; dmp = 3'd1;
    do_reset();
    fmax = 24'sd1000; lim = 1'b1;
    smp(1000); mdl(1000, 6, 12);
    chk("R10 clamp at max", longint'(freq), 1000);
    smp(-1); mdl(-1, 6, 12);
    chk("R9 frozen integrator", longint'(freq), 58);
    smp(-1); mdl(-1, 6, 12);
    chk("R9 integrator resumes off limit", longint'(freq), 57);
    do_reset();
    lim = 1'b0;
    smp(1000); mdl(1000, 6, 12);
    smp(-1); mdl(-1, 6, 12);
    chk("R9 no freeze when disabled", longint'(freq), 57);
    do_reset();
    fmax = FW'(HI_W); fmin = -24'sd500;
    smp(-1000); mdl(-1000, 6, 12);
    chk("R10 clamp at min", longint'(freq), -500);
    fmin = FW'(LO_W);

    // holdover behaviour, p=1 i=2
    lcb = 3'd5;
    do_reset();
    smp(400); mdl(400, 1, 2);
    snap_a = m_acc;
    repeat (70) @(negedge clk);
    smp(-200); mdl(-200, 1, 2);
    chk("R8 sample B", longint'(freq), m_frq);
    ref_ok = 1'b0; vld = 1'b1; err = 16'sd1000;
    @(negedge clk);
    vld = 1'b0;
    chk("R1 mini entered", longint'(mini), 1);
    chk("R2 older snapshot", longint'(freq), snap_a);
    smp(1000);
    repeat (70) @(negedge clk);
    chk("R1 samples ignored in mini", longint'(freq), snap_a);
    ref_ok = 1'b1;
    @(negedge clk);
    chk("R3 mini left on return", longint'(mini), 0);
    smp(0); mdl(0, 1, 2);
    chk("R11 integrator kept", longint'(freq), m_acc);
    smp(100); mdl(100, 1, 2);
    hold = 1'b1;
    @(negedge clk);
    chk("R3 hold outputs integrator", longint'(freq), m_acc);
    smp(1000);
    chk("R3 samples ignored in hold", longint'(freq), m_acc);
    hold = 1'b0;
    repeat (70) @(negedge clk);
    ref_ok = 1'b0;
    @(negedge clk);
    chk("R2 snapshot refreshed", longint'(freq), m_acc);
    hold = 1'b1;
    @(negedge clk);
    chk("R3 hold ends mini", longint'(mini), 0);
    hold = 1'b0;
    ofs = 24'sd5000; frun = 1'b1;
    @(negedge clk);
    chk("R1 mini re-entered", longint'(mini), 1);
    chk("R4 free-run word", longint'(freq), 5100);
    frun = 1'b0; ref_ok = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule